// File: doc/BRIEF.md
# Deflection Polynomial Waveform Generator

This block produces, once per display line, one vertical deflection sample and one east/west correction sample for a CRT. Each waveform is a sixth-order polynomial in the number of lines since the start of the field. The vertical polynomial is normally set up as a sawtooth, and its higher-order terms bend it for linearity and S-correction. The east/west polynomial is normally a parabola, and its higher-order terms add trapezoid, pincushion and top/bottom corner correction. Each polynomial is stepped by a chain of forward-difference accumulators. The chain reloads at every field start and advances by one step on each line strobe.

Both raw samples are multiplied by one programmable gain. Each product is then clamped to a window of its own. Together these give vertical zoom or compression of the picture. The vertical sample leaves the block as a differential pair in offset binary. The east/west sample leaves as a signed value.

Coefficients, gain and limits are written through a simple write port. A write is held in a staging copy and takes effect only at the next field start, so a waveform never jumps in the middle of a field.

Top module: `defl_poly_gen`

## Requirements
- R1: After reset, `vert_pos` is 0x8000, `vert_neg` is 0x7FFF, `ew_out` is 0 and `sample_valid` is 0. The gain resets to 1.0 (0x4000). Each lower limit resets to 0x8000 and each upper limit to 0x7FFF. All initial differences reset to zero.
- R2: After the n-th line strobe of a field, the raw vertical sample is bits [31:16] of the 32-bit value p(n) = sum over k = 0..6 of C(n,k)*Dv[k], computed modulo 2^32. Dv[k] is the vertical initial difference of order k, written at address k (0..6).
- R3: The east/west sample follows the same rule with its own differences De[k], written at address 8+k.
- R4: A field-start pulse resets the step count to zero. A line strobe in the same cycle as field start produces the step-zero sample, p(0) = D[0], computed from the reloaded values.
- R5: Scaling multiplies the signed 16-bit raw sample by the unsigned Q2.14 gain written at address 16. The result is then shifted right arithmetically by 14, which rounds toward minus infinity.
- R6: The scaled vertical value is clamped to the signed window [address 17, address 18]. The scaled east/west value is clamped to [address 19, address 20]. Both are applied only after scaling.
- R7: `vert_pos` is the clamped vertical value with bit 15 inverted (offset binary). `vert_neg` is the bitwise inverse of `vert_pos`.
- R8: A write to any coefficient, gain or limit has no effect on samples until the next field-start pulse.
- R9: `sample_valid` goes high for one cycle exactly one cycle after each line strobe, and new sample values appear in that same cycle. All three outputs hold their values at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| line_strobe | input | 1 | One-cycle pulse once per display line |
| cfg_we | input | 1 | Write enable for the staging registers |
| cfg_addr | input | 5 | Write address: 0..6 vertical differences, 8..14 east/west differences, 16 gain, 17/18 vertical low/high limit, 19/20 east/west low/high limit |
| cfg_wdata | input | 32 | Write data. Gain uses the low 16 bits, limits use the low 16 bits as a signed value |
| vert_pos | output | 16 | Vertical sample, offset binary |
| vert_neg | output | 16 | Complement of `vert_pos` about midscale |
| ew_out | output | 16 | East/west sample, signed |
| sample_valid | output | 1 | One-cycle pulse marking fresh samples |

## Verification
A line strobe seen at clock edge E moves the accumulator chain at E. The scaled, clamped samples are registered at E+1, and `sample_valid` rises at E+1 as well, so each result is due one cycle after its strobe. The bench drives inputs on the falling edge. For each strobe it pushes the expected triple, computed from binomial sums and the field-start snapshot of the staged registers. A monitor pops and compares that triple on the falling edge in which `sample_valid` is high, which is half a cycle after the samples settled. A valid pulse that arrives with no expected item, or an item still left in the queue at the end, is a failure.

// File: rtl/defl_pkg.sv
package defl_pkg;

   // Offsets of the control words inside the control slot of the map.
   localparam int CTL_GAIN = 0;
   localparam int CTL_VLO  = 1;
   localparam int CTL_VHI  = 2;
   localparam int CTL_ELO  = 3;
   localparam int CTL_EHI  = 4;
   localparam int CTL_CNT  = 5;

   // Each address slot holds ORDER+1 differences and is at least 8 wide.
   function automatic int slot_size(input int order);
      int s;
      s = 1;
      while (s < order + 1) s = s * 2;
      if (s < 8) s = 8;
      return s;
   endfunction

endpackage

// File: rtl/defl_fd_chain.sv
module defl_fd_chain #(
   parameter int ORDER = 6,
   parameter int ACC_W = 32,
   parameter int OUT_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        field_start,
   input  logic                        line_strobe,
   input  logic [ORDER:0][ACC_W-1:0]   init_diff,
   output logic [OUT_W-1:0]            head_msb
);

   logic [ACC_W-1:0] acc [ORDER+1];

   generate
      for (genvar k = 0; k <= ORDER; k++) begin : g_stage
         if (k == ORDER) begin : g_top
            // highest difference is constant within a field
            always_ff @(posedge clk) begin
               if (!rst_n)           acc[k] <= '0;
               else if (field_start) acc[k] <= init_diff[k];
            end
         end else begin : g_mid
            always_ff @(posedge clk) begin
               if (!rst_n)           acc[k] <= '0;
               else if (field_start) acc[k] <= init_diff[k];
               else if (line_strobe) acc[k] <= acc[k] + acc[k+1];
            end
         end
      end
   endgenerate

   assign head_msb = acc[0][ACC_W-1 -: OUT_W];

   AST_TOP_TERM_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start |=> $stable(acc[ORDER])); // R2

   AST_RELOAD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> acc[0] == $past(init_diff[0])); // R4

endmodule

// File: rtl/defl_scale_clamp.sv
module defl_scale_clamp #(
   parameter int OUT_W     = 16,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 14,
   parameter bit ROUND     = 1'b0
) (
   input  logic signed [OUT_W-1:0] sample,
   input  logic        [GAIN_W-1:0] gain,
   input  logic signed [OUT_W-1:0] lim_lo,
   input  logic signed [OUT_W-1:0] lim_hi,
   output logic signed [OUT_W-1:0] result
);

   localparam int PW = OUT_W + GAIN_W + 1;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] biased;
   logic signed [PW-1:0] shifted;

   assign prod = PW'(sample) * PW'($signed({1'b0, gain}));

   generate
      if (ROUND) begin : g_round
         assign biased = prod + (PW'(1) <<< (GAIN_FRAC - 1));
      end else begin : g_floor
         assign biased = prod;
      end
   endgenerate

   assign shifted = biased >>> GAIN_FRAC;

   always_comb begin
      if (shifted > PW'(lim_hi))      result = lim_hi;
      else if (shifted < PW'(lim_lo)) result = lim_lo;
      else                            result = shifted[OUT_W-1:0];
   end

endmodule

// File: rtl/defl_reg_bank.sv
module defl_reg_bank
   import defl_pkg::*;
#(
   parameter int ORDER     = 6,
   parameter int ACC_W     = 32,
   parameter int OUT_W     = 16,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 14,
   parameter int ADDR_W    = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       field_start,
   input  logic                       cfg_we,
   input  logic [ADDR_W-1:0]          cfg_addr,
   input  logic [ACC_W-1:0]           cfg_wdata,
   output logic [ORDER:0][ACC_W-1:0]  vert_init,
   output logic [ORDER:0][ACC_W-1:0]  ew_init,
   output logic [GAIN_W-1:0]          gain_act,
   output logic [OUT_W-1:0]           vlo_act,
   output logic [OUT_W-1:0]           vhi_act,
   output logic [OUT_W-1:0]           elo_act,
   output logic [OUT_W-1:0]           ehi_act
);

   localparam int SLOT  = slot_size(ORDER);
   localparam int EBASE = SLOT;
   localparam int CBASE = 2 * SLOT;
   localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << GAIN_FRAC;
   localparam logic [OUT_W-1:0]  SMIN     = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic [OUT_W-1:0]  SMAX     = {1'b0, {(OUT_W-1){1'b1}}};

   logic [GAIN_W-1:0] gain_stg;
   logic [OUT_W-1:0]  lim_stg [4];

   // Differences are read by the chain only at field start, so the
   // staging copy alone gives the deferred behaviour.
   generate
      for (genvar k = 0; k <= ORDER; k++) begin : g_diff
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vert_init[k] <= '0;
               ew_init[k]   <= '0;
            end else if (cfg_we) begin
               if (cfg_addr == ADDR_W'(k))         vert_init[k] <= cfg_wdata;
               if (cfg_addr == ADDR_W'(EBASE + k)) ew_init[k]   <= cfg_wdata;
            end
         end
      end
      for (genvar j = 0; j < 4; j++) begin : g_lim
         always_ff @(posedge clk) begin
            if (!rst_n)
               lim_stg[j] <= (j % 2 == 0) ? SMIN : SMAX;
            else if (cfg_we && cfg_addr == ADDR_W'(CBASE + CTL_VLO + j))
               lim_stg[j] <= cfg_wdata[OUT_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         gain_stg <= GAIN_ONE;
      else if (cfg_we && cfg_addr == ADDR_W'(CBASE + CTL_GAIN))
         gain_stg <= cfg_wdata[GAIN_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_act <= GAIN_ONE;
         vlo_act  <= SMIN;
         vhi_act  <= SMAX;
         elo_act  <= SMIN;
         ehi_act  <= SMAX;
      end else if (field_start) begin
         gain_act <= gain_stg;
         vlo_act  <= lim_stg[0];
         vhi_act  <= lim_stg[1];
         elo_act  <= lim_stg[2];
         ehi_act  <= lim_stg[3];
      end
   end

   AST_GAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start |=> $stable(gain_act) && $stable(vhi_act) && $stable(ehi_act)); // R8

endmodule

// File: rtl/defl_poly_gen.sv
module defl_poly_gen
   import defl_pkg::*;
#(
   parameter int ORDER     = 6,
   parameter int ACC_W     = 32,
   parameter int OUT_W     = 16,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 14,
   parameter bit ROUND     = 1'b0,
   localparam int ADDR_W   = $clog2(slot_size(ORDER)) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic              line_strobe,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [ACC_W-1:0]  cfg_wdata,
   output logic [OUT_W-1:0]  vert_pos,
   output logic [OUT_W-1:0]  vert_neg,
   output logic [OUT_W-1:0]  ew_out,
   output logic              sample_valid
);

   localparam logic [OUT_W-1:0] MID = {1'b1, {(OUT_W-1){1'b0}}};

   generate
      if (ORDER < 1) begin : g_bad_order
         $error("ORDER must be at least 1");
      end
      if (OUT_W > ACC_W) begin : g_bad_width
         $error("OUT_W must not exceed ACC_W");
      end
      if (GAIN_FRAC < 1 || GAIN_FRAC >= GAIN_W) begin : g_bad_gain
         $error("GAIN_FRAC must lie in 1..GAIN_W-1");
      end
      if (GAIN_W > ACC_W || CTL_CNT > slot_size(ORDER)) begin : g_bad_map
         $error("control words do not fit the write map");
      end
   endgenerate

   logic [ORDER:0][ACC_W-1:0] vert_init, ew_init;
   logic [GAIN_W-1:0]         gain_act;
   logic [OUT_W-1:0]          vlo, vhi, elo, ehi;
   logic [OUT_W-1:0]          v_raw, e_raw;
   logic signed [OUT_W-1:0]   v_clip, e_clip;
   logic                      strobe_d;

   defl_reg_bank #(
      .ORDER(ORDER), .ACC_W(ACC_W), .OUT_W(OUT_W),
      .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .field_start(field_start),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .vert_init(vert_init), .ew_init(ew_init), .gain_act(gain_act),
      .vlo_act(vlo), .vhi_act(vhi), .elo_act(elo), .ehi_act(ehi)
   );

   defl_fd_chain #(.ORDER(ORDER), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_vchain (
      .clk(clk), .rst_n(rst_n), .field_start(field_start),
      .line_strobe(line_strobe), .init_diff(vert_init), .head_msb(v_raw)
   );

   defl_fd_chain #(.ORDER(ORDER), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_echain (
      .clk(clk), .rst_n(rst_n), .field_start(field_start),
      .line_strobe(line_strobe), .init_diff(ew_init), .head_msb(e_raw)
   );

   defl_scale_clamp #(
      .OUT_W(OUT_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .ROUND(ROUND)
   ) u_vscale (
      .sample($signed(v_raw)), .gain(gain_act),
      .lim_lo($signed(vlo)), .lim_hi($signed(vhi)), .result(v_clip)
   );

   defl_scale_clamp #(
      .OUT_W(OUT_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .ROUND(ROUND)
   ) u_escale (
      .sample($signed(e_raw)), .gain(gain_act),
      .lim_lo($signed(elo)), .lim_hi($signed(ehi)), .result(e_clip)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_d     <= 1'b0;
         sample_valid <= 1'b0;
         vert_pos     <= MID;
         vert_neg     <= ~MID;
         ew_out       <= '0;
      end else begin
         strobe_d     <= line_strobe;
         sample_valid <= strobe_d;
         if (strobe_d) begin
            vert_pos <= v_clip ^ MID;
            vert_neg <= ~(v_clip ^ MID);
            ew_out   <= e_clip;
         end
      end
   end

   AST_VALID_TWO_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(line_strobe) |=> sample_valid); // R9

   AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> $past(strobe_d)); // R9

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |-> $stable(ew_out) && $stable(vert_pos)); // R9

   AST_DIFF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (vert_neg ^ vert_pos) == '1); // R7

   AST_VERT_WITHIN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid && $signed($past(vlo)) <= $signed($past(vhi)) |->
         $signed(vert_pos ^ MID) >= $signed($past(vlo)) &&
         $signed(vert_pos ^ MID) <= $signed($past(vhi))); // R6

   AST_EW_WITHIN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid && $signed($past(elo)) <= $signed($past(ehi)) |->
         $signed(ew_out) >= $signed($past(elo)) &&
         $signed(ew_out) <= $signed($past(ehi))); // R6

endmodule

// File: tb/tb_defl_poly_gen.sv
`timescale 1ns/1ps
module tb_defl_poly_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        field_start = 1'b0;
   logic        line_strobe = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [15:0] vert_pos, vert_neg, ew_out;
   logic        sample_valid;

   always #10 clk = ~clk;

   defl_poly_gen dut (
      .clk(clk), .rst_n(rst_n), .field_start(field_start),
      .line_strobe(line_strobe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .vert_pos(vert_pos), .vert_neg(vert_neg),
      .ew_out(ew_out), .sample_valid(sample_valid)
   );

   typedef struct {
      logic [15:0] vp;
      logic [15:0] vn;
      logic [15:0] ew;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   // bench-side model of staged and active settings
   logic [31:0] stg_v[7], stg_e[7], cur_v[7], cur_e[7];
   logic [15:0] stg_gain = 16'h4000, cur_gain = 16'h4000;
   logic [15:0] stg_lim[4] = '{16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF};
   logic [15:0] cur_lim[4] = '{16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF};
   int          step = 0;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   function automatic longint poly(input logic [31:0] d[7], input int n);
      longint sum = 0;
      longint c = 1;
      for (int k = 0; k <= 6; k++) begin
         if (k > n) break;
         sum += c * longint'($signed(d[k]));
         c = c * (n - k) / (k + 1);
      end
      return sum;
   endfunction

   function automatic logic [15:0] shape(input longint p, input logic [15:0] g,
                                         input logic [15:0] lo, input logic [15:0] hi);
      logic [31:0] w;
      longint s, sc;
      w  = p[31:0];
      s  = longint'($signed(w[31:16]));
      sc = (s * longint'(g)) >>> 14;
      if (sc > longint'($signed(hi))) return hi;
      if (sc < longint'($signed(lo))) return lo;
      return sc[15:0];
   endfunction

   task automatic push_exp(input string tag);
      exp_t e;
      logic [15:0] v;
      v = shape(poly(cur_v, step), cur_gain, cur_lim[0], cur_lim[1]);
      e.vp  = v ^ 16'h8000;
      e.vn  = ~(v ^ 16'h8000);
      e.ew  = shape(poly(cur_e, step), cur_gain, cur_lim[2], cur_lim[3]);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      if (a <= 6)                  stg_v[a] = d;
      else if (a >= 8 && a <= 14)  stg_e[a-8] = d;
      else if (a == 16)            stg_gain = d[15:0];
      else if (a >= 17 && a <= 20) stg_lim[a-17] = d[15:0];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic field(input bit with_strobe, input string tag);
      @(negedge clk);
      field_start = 1'b1;
      line_strobe = with_strobe;
      cur_v = stg_v; cur_e = stg_e; cur_gain = stg_gain; cur_lim = stg_lim;
      step = 0;
      if (with_strobe) push_exp(tag);
      @(negedge clk);
      field_start = 1'b0;
      line_strobe = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic strobe(input string tag);
      @(negedge clk);
      line_strobe = 1'b1;
      step++;
      push_exp(tag);
      @(negedge clk);
      line_strobe = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // monitor: one expected item per valid pulse (R9)
   always @(negedge clk) begin
      if (rst_n && sample_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9: actual=valid pulse expected=no pulse");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " vert_pos"}, vert_pos, e.vp);
            check("R7 vert_neg", vert_neg, e.vn);
            check({e.tag, " ew_out"}, ew_out, e.ew);
         end
      end
   end

   initial begin
      #(20ns * 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 7; k++) begin stg_v[k] = '0; stg_e[k] = '0; end
      cur_v = stg_v; cur_e = stg_e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 vert_pos", vert_pos, 16'h8000);
      check("R1 vert_neg", vert_neg, 16'h7FFF);
      check("R1 ew_out", ew_out, 16'h0000);
      check("R1 sample_valid", {15'd0, sample_valid}, 16'h0000);

      // R2/R3 polynomials at unity gain and full limits
      wr(0, 32'hC000_0000); wr(1, 32'h0100_0000); wr(2, 32'h0000_4000);
      wr(3, 32'h0000_0100); wr(4, 32'h0000_0010); wr(5, 32'h0000_0004);
      wr(6, 32'h0000_0001);
      wr(8, 32'h0800_0000); wr(9, 32'hFFC0_0000); wr(10, 32'h0008_0000);
      wr(11, 32'h0000_2000); wr(12, 32'h0000_1000); wr(13, 32'h0000_0200);
      wr(14, 32'h0000_0040);
      field(1'b0, "R4");
      for (int i = 0; i < 8; i++) strobe("R2/R3");

      // R4 coincident field start and strobe gives step zero
      field(1'b1, "R4 step0");
      for (int i = 0; i < 3; i++) strobe("R4");

      // R8 mid-field writes are deferred
      wr(1, 32'h0200_0000); wr(16, 32'h0000_2000); wr(12, 32'h0001_0000);
      for (int i = 0; i < 2; i++) strobe("R8 deferred");
      field(1'b0, "R8");
      for (int i = 0; i < 4; i++) strobe("R5 gain0.5");

      // R5/R6 gain 2.0 with narrow windows
      wr(16, 32'h0000_8000);
      wr(17, 32'h0000_D000); wr(18, 32'h0000_2000);
      wr(19, 32'h0000_0C00); wr(20, 32'h0000_1400);
      field(1'b1, "R6 step0");
      for (int i = 0; i < 48; i++) strobe("R6 clamp");

      repeat (4) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R9: actual=%0d pending expected=0 pending", exp_q.size());
      end
      finish_run();
   end

endmodule